// File: doc/BRIEF.md
# Dual-Glyph LED Column Scanner

This block refreshes two 5x7 dot-matrix LED displays whose row lines are tied together. The ten display columns are enabled one at a time by an external walking-one shift register, which the block controls through a clock line, a data line and an active-low clear line. Columns 0 to 4 belong to the right display and columns 5 to 9 to the left display. Each column stays lit for eight sample ticks, and the block then moves to the next one.

For each column the block reads an 8-bit active-low row pattern from an internal glyph table. At column 0 the table address is loaded from a right-side start address, and at column 5 from a left-side start address. The address then steps by one per column. Patterns for the left display are bit-mirrored, so one table serves both displays even though the left display is wired the other way round. The surrounding logic supplies the two start addresses, and each one selects a glyph (address = glyph index x 8).

Top module: `dual_glyph_scanner`

## Requirements
- R1: While reset is asserted, row_n is 8'hFF, sr_clk is 1, sr_data is 0 and sr_clr_n is 0. After reset is released, sr_clr_n rises at the first clock edge and stays 1.
- R2: Each column strobe is an sr_clk low phase of exactly one clock cycle. Consecutive low phases start exactly 8*TICK_CYCLES clock cycles apart.
- R3: sr_data is 1 at the rising edge of sr_clk only for the strobe of column 0. The columns run 0..9 and then wrap, and the first strobe after reset is column 0. sr_data is 0 one cycle after the rising edge, and it stays 0 at every other strobe.
- R4: For columns 0 to 4, row_n takes the unmirrored table byte at address right_base + column. It changes only in the cycle after the rising edge of sr_clk and holds its value at all other times.
- R5: For columns 5 to 9, row_n takes the mirrored table byte at address left_base + (column - 5).
- R6: Mirroring maps the fetched byte p to an output o with o[6-k] = p[k] for k = 0..6, and o[7] = p[0]. Bit p[7] is dropped.
- R7: The table is addressed by 6 bits. Bits [5:3] are the glyph index g and bits [2:0] are the column c. For c < 5 the byte is 8'hFF XOR (1 << ((g + c) mod 7)). For c >= 5 the byte is 8'hFF (all LEDs off).
- R8: The address step wraps modulo 64. For example, a start address of 62 reads 62, 63, 0, 1 and 2.
- R9: A start address is sampled only at the column-0 strobe (right) or the column-5 strobe (left). A change at any other time has no effect until the next such strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| right_base | input | 6 | Start address for the right display's glyph |
| left_base | input | 6 | Start address for the left display's glyph |
| sr_clk | output | 1 | Shift-register clock, pulsed low for one cycle per column |
| sr_data | output | 1 | Shift-register serial data, 1 only for the column-0 strobe |
| sr_clr_n | output | 1 | Shift-register clear, low during reset |
| row_n | output | 8 | Active-low row drive shared by both displays |

## Verification
Several properties are checked on every cycle:
- the one-cycle low phase of sr_clk;
- sr_data dropping right after the strobe and appearing only in column 0;
- row_n holding still except in the cycle after a strobe;
- the clear line staying high once reset has ended.

Other behaviours only the bench scenarios can show:
- the table contents;
- the mirrored ordering on the left half;
- address wrap past 63;
- start addresses being ignored between their sampling strobes;
- the exact strobe period.

For these, the bench follows a column model through randomly changing start addresses and a directed wrap case.

// File: rtl/dual_glyph_scanner.sv
module dual_glyph_scanner #(
  parameter int TICK_CYCLES   = 27800,
  parameter int TICKS_PER_COL = 8,
  parameter int COLS_PER_SIDE = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] right_base,
  input  logic [5:0] left_base,
  output logic       sr_clk,
  output logic       sr_data,
  output logic       sr_clr_n,
  output logic [7:0] row_n
);
  localparam int NCOL = 2 * COLS_PER_SIDE;
  localparam int CW   = $clog2(NCOL);
  localparam int TW   = $clog2(TICK_CYCLES + 1);
  localparam int SW   = $clog2(TICKS_PER_COL + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_LOW, PH_HIGH} phase_t;

  logic [TW-1:0] tdiv;
  logic [SW-1:0] sub;
  logic [CW-1:0] col;
  logic [5:0]    addr;
  logic [7:0]    rom_q;
  phase_t        ph;
  logic          tick, step, left_half;

  function automatic logic [7:0] glyph_byte(input logic [5:0] a);
    logic [3:0] idx;
    idx = ({1'b0, a[5:3]} + {1'b0, a[2:0]}) % 4'd7;
    if (a[2:0] >= 3'd5) return 8'hFF;
    return 8'hFF ^ (8'd1 << idx[2:0]);
  endfunction

  function automatic logic [7:0] flip(input logic [7:0] p);
    logic [7:0] o;
    o[7] = p[0];
    for (int k = 0; k < 7; k++) o[6-k] = p[k];
    return o;
  endfunction

  assign tick      = (tdiv == TW'(TICK_CYCLES - 1));
  assign step      = tick && (sub == SW'(TICKS_PER_COL - 1)) && (ph == PH_IDLE);
  assign left_half = (col >= CW'(COLS_PER_SIDE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv <= '0;
      sub  <= '0;
    end else begin
      tdiv <= tick ? '0 : tdiv + 1'b1;
      if (tick) sub <= (sub == SW'(TICKS_PER_COL - 1)) ? '0 : sub + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rom_q <= 8'hFF;
    else        rom_q <= glyph_byte(addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      col      <= '0;
      addr     <= '0;
      sr_clk   <= 1'b1;
      sr_data  <= 1'b0;
      sr_clr_n <= 1'b0;
      row_n    <= 8'hFF;
    end else begin
      sr_clr_n <= 1'b1;
      unique case (ph)
        PH_IDLE: if (step) begin
          sr_data <= (col == '0);
          if (col == '0)                      addr <= right_base;
          else if (col == CW'(COLS_PER_SIDE)) addr <= left_base;
          ph <= PH_LOAD;
        end
        PH_LOAD: begin
          sr_clk <= 1'b0;
          ph     <= PH_LOW;
        end
        PH_LOW: begin
          sr_clk <= 1'b1;
          ph     <= PH_HIGH;
        end
        PH_HIGH: begin
          sr_data <= 1'b0;
          row_n   <= left_half ? flip(rom_q) : rom_q;
          addr    <= addr + 6'd1;
          col     <= (col == CW'(NCOL - 1)) ? '0 : col + 1'b1;
          ph      <= PH_IDLE;
        end
      endcase
    end
  end

  p_clk_low_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_clk |=> sr_clk);

  p_data_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_clk) |=> !sr_data);

  p_data_col0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_data |-> (col == '0));

  p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sr_clk) |=> $stable(row_n));

  p_clr_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sr_clr_n |=> sr_clr_n);

  p_col_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col < CW'(NCOL));
endmodule

// File: tb/dual_glyph_scanner_bench.sv
`timescale 1ns/1ps
module dual_glyph_scanner_bench;
  localparam int TICK = 4;
  localparam int PERIOD = 8 * TICK;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] right_base = '0, left_base = '0;
  logic sr_clk, sr_data, sr_clr_n;
  logic [7:0] row_n;

  int checks = 0, fails = 0, cyc = 0;
  bit wd = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) wd <= 1'b1;
  end

  dual_glyph_scanner #(.TICK_CYCLES(TICK)) u_dual_glyph_scanner (
    .clk(clk), .rst_n(rst_n), .right_base(right_base), .left_base(left_base),
    .sr_clk(sr_clk), .sr_data(sr_data), .sr_clr_n(sr_clr_n), .row_n(row_n));

  function automatic logic [7:0] table_ref(input logic [5:0] a);
    int g, c;
    g = int'(a[5:3]);
    c = int'(a[2:0]);
    if (c >= 5) return 8'hFF;
    return 8'hFF ^ (8'd1 << ((g + c) % 7));
  endfunction

  function automatic logic [7:0] mirror_ref(input logic [7:0] p);
    logic [7:0] o;
    o[7] = p[0];
    for (int k = 0; k < 7; k++) o[6-k] = p[k];
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    int col = 0, last_low = -1, low_at;
    logic [5:0] a = '0, rb_l, lb_l;
    logic [7:0] p, exp;
    void'($urandom(32'd1357));
    right_base = 6'h3E;
    left_base  = 6'h07;
    repeat (3) @(negedge clk);
    check("R1 row_n", row_n, 8'hFF);
    check("R1 sr_clk", sr_clk, 1);
    check("R1 sr_data", sr_data, 0);
    check("R1 sr_clr_n", sr_clr_n, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 clear released", sr_clr_n, 1);

    for (int n = 0; n < 90 && !wd; n++) begin
      while (sr_clk && !wd) @(negedge clk);
      if (wd) break;
      low_at = cyc;
      if (last_low >= 0) check("R2 strobe period", low_at - last_low, PERIOD);
      last_low = low_at;
      rb_l = right_base;
      lb_l = left_base;
      @(negedge clk);
      check("R2 low one cycle", sr_clk, 1);
      check("R3 data at strobe", sr_data, (col == 0));
      @(negedge clk);
      check("R3 data low after", sr_data, 0);
      if (col == 0) a = rb_l;
      else if (col == 5) a = lb_l;
      p = table_ref(a);
      exp = (col >= 5) ? mirror_ref(p) : p;
      if (col >= 5) check("R5 R6 left mirrored row", row_n, exp);
      else check("R4 R7 R8 right row", row_n, exp);
      a = a + 6'd1;
      col = (col == 9) ? 0 : col + 1;
      // R9: bases change at arbitrary points, including mid-group
      if (n < 10) begin
        if (n == 2) right_base = 6'h15;
        if (n == 7) left_base = 6'h3F;
      end else if ($urandom % 3 == 0) begin
        right_base = 6'($urandom);
        left_base  = 6'($urandom);
      end
      repeat (2) @(negedge clk);
      check("R4 row hold", row_n, exp);
    end
    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule